// File: doc/BRIEF.md
# Interrupt Mask and Priority Arbiter

This block keeps the two interrupt mask bits of a processor core and decides which reset or interrupt source the core services next. Its inputs are three reset-class requests (power-on or reset pin, clock monitor, watchdog), a nonmaskable pin interrupt, an illegal-opcode trap, a software interrupt and a parameterised vector of maskable peripheral requests. It also accepts software writes to the mask bits and a restore command issued by the return-from-interrupt sequence.

The two mask bits do not behave alike. The I bit masks the peripheral requests, and software may set or clear it. The X bit masks only the nonmaskable pin interrupt. Software can clear X but can never set it again. Only reset, the entry into an X-related source, or a return-from-interrupt restore can set X. Each cycle the block picks the highest-ranked eligible source and reports its index and its 16-bit vector address. It raises a take strobe, and on the following clock edge it updates the masks the way the entry of that source requires. Stacking, instruction sequencing and memory access belong to the surrounding core.

Top module: `intmask_arb`

## Requirements
- R1: After reset both mask bits are 1 and no ordinary interrupt is taken.
- R2: A software write (`sw_wr`) loads I from `sw_i`. X becomes 0 when `sw_x` is 0 and is left unchanged when `sw_x` is 1, so a write never sets X.
- R3: A restore (`rti_restore`) loads X from `rti_x` and I from `rti_i`, and this can set X.
- R4: When several mask updates coincide, an entry (`take`) wins over a restore, and a restore wins over a software write.
- R5: Peripheral requests are eligible only while I is 0. The pin interrupt is eligible only while X is 0 and does not depend on I.
- R6: The illegal-opcode trap and the software interrupt are eligible whatever the mask bits hold.
- R7: Sources are ranked from highest to lowest with fixed indices: power-on/reset pin 0, clock monitor 1, watchdog 2, pin interrupt 3, illegal opcode 4, software interrupt 5.
- R8: Peripheral request k has index 6+k. Every peripheral ranks below all six nonmaskable sources, and among the peripherals the lowest k wins. Its vector comes from a parameter table whose default gives peripheral k the address 16'hFFF2 - 2k.
- R9: Interrupt sources (indices 3 and up) are taken only in a cycle with `insn_boundary` high. Reset-class sources (indices 0 to 2) are taken in any cycle.
- R10: On the clock edge after `take`, I is 1. X becomes 1 if the taken index is 3 or less, and X is left unchanged otherwise.
- R11: Default nonmaskable vectors: index 0 16'hFFFE, 1 16'hFFFC, 2 16'hFFFA, 3 16'hFFF4, 4 16'hFFF8, 5 16'hFFF6.
- R12: While `take` is 0, `src_idx` and `vec_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_por | input | 1 | Power-on or reset pin request |
| req_clkmon | input | 1 | Clock monitor reset request |
| req_wdog | input | 1 | Watchdog reset request |
| req_xpin | input | 1 | Nonmaskable pin interrupt request |
| req_illop | input | 1 | Illegal-opcode trap request |
| req_swi | input | 1 | Software interrupt request |
| req_periph | input | NPERIPH | Maskable peripheral requests |
| insn_boundary | input | 1 | High when the current instruction completes |
| sw_wr | input | 1 | Software write to the mask bits |
| sw_x | input | 1 | Written X value (can only clear) |
| sw_i | input | 1 | Written I value |
| rti_restore | input | 1 | Restore masks from the stacked byte |
| rti_x | input | 1 | Stacked X value |
| rti_i | input | 1 | Stacked I value |
| take | output | 1 | A source is being taken this cycle |
| src_idx | output | IDXW | Index of the taken source |
| vec_addr | output | 16 | Vector address of the taken source |
| mask_x | output | 1 | Current X mask bit |
| mask_i | output | 1 | Current I mask bit |

## Verification
The assertions assume that the core holds each request steady over a cycle. They also assume that `rti_restore` and `sw_wr` are single-cycle pulses and that the core never asks for a restore and a software write to be ignored at the same time. With those assumptions, every rise of X can be traced back to a take or a restore in the cycle before. The stimulus drives every input on the falling clock edge and clears each pulse on the next falling edge. Combinational priority is checked by changing requests inside one low clock phase and returning them to idle before the rising edge, so that no unintended entry changes the masks.

// File: rtl/intmask_arb.sv
module intmask_arb #(
  parameter int NPERIPH = 8,
  parameter logic [15:0] VEC_POR    = 16'hFFFE,
  parameter logic [15:0] VEC_CLKMON = 16'hFFFC,
  parameter logic [15:0] VEC_WDOG   = 16'hFFFA,
  parameter logic [15:0] VEC_XPIN   = 16'hFFF4,
  parameter logic [15:0] VEC_ILLOP  = 16'hFFF8,
  parameter logic [15:0] VEC_SWI    = 16'hFFF6,
  parameter logic [NPERIPH-1:0][15:0] PERIPH_VEC =
    {16'hFFE4, 16'hFFE6, 16'hFFE8, 16'hFFEA, 16'hFFEC, 16'hFFEE, 16'hFFF0, 16'hFFF2},
  localparam int NSRC = 6 + NPERIPH,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_por,
  input  logic               req_clkmon,
  input  logic               req_wdog,
  input  logic               req_xpin,
  input  logic               req_illop,
  input  logic               req_swi,
  input  logic [NPERIPH-1:0] req_periph,
  input  logic               insn_boundary,
  input  logic               sw_wr,
  input  logic               sw_x,
  input  logic               sw_i,
  input  logic               rti_restore,
  input  logic               rti_x,
  input  logic               rti_i,
  output logic               take,
  output logic [IDXW-1:0]    src_idx,
  output logic [15:0]        vec_addr,
  output logic               mask_x,
  output logic               mask_i
);

  localparam logic [IDXW-1:0] IDX_POR    = IDXW'(0);
  localparam logic [IDXW-1:0] IDX_CLKMON = IDXW'(1);
  localparam logic [IDXW-1:0] IDX_WDOG   = IDXW'(2);
  localparam logic [IDXW-1:0] IDX_XPIN   = IDXW'(3);
  localparam logic [IDXW-1:0] IDX_ILLOP  = IDXW'(4);
  localparam logic [IDXW-1:0] IDX_SWI    = IDXW'(5);

  logic               any_reset, any_int, xpin_ok, x_related;
  logic [NPERIPH-1:0] periph_ok;
  logic [IDXW-1:0]    sel_idx;
  logic [15:0]        sel_vec;

  assign xpin_ok   = req_xpin & ~mask_x;
  assign periph_ok = req_periph & {NPERIPH{~mask_i}};
  assign any_reset = req_por | req_clkmon | req_wdog;
  assign any_int   = xpin_ok | req_illop | req_swi | (|periph_ok);
  assign take      = any_reset | (insn_boundary & any_int);
  assign src_idx   = take ? sel_idx : '0;
  assign vec_addr  = take ? sel_vec : '0;
  assign x_related = sel_idx <= IDX_XPIN;

  always_comb begin
    sel_idx = '0;
    sel_vec = '0;
    if (req_por) begin
      sel_idx = IDX_POR;    sel_vec = VEC_POR;
    end else if (req_clkmon) begin
      sel_idx = IDX_CLKMON; sel_vec = VEC_CLKMON;
    end else if (req_wdog) begin
      sel_idx = IDX_WDOG;   sel_vec = VEC_WDOG;
    end else if (xpin_ok) begin
      sel_idx = IDX_XPIN;   sel_vec = VEC_XPIN;
    end else if (req_illop) begin
      sel_idx = IDX_ILLOP;  sel_vec = VEC_ILLOP;
    end else if (req_swi) begin
      sel_idx = IDX_SWI;    sel_vec = VEC_SWI;
    end else begin
      for (int k = NPERIPH - 1; k >= 0; k--) begin
        if (periph_ok[k]) begin
          sel_idx = IDXW'(6 + k);
          sel_vec = PERIPH_VEC[k];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_x <= 1'b1;
      mask_i <= 1'b1;
    end else if (take) begin
      mask_i <= 1'b1;
      if (x_related) mask_x <= 1'b1;
    end else if (rti_restore) begin
      mask_x <= rti_x;
      mask_i <= rti_i;
    end else if (sw_wr) begin
      mask_x <= mask_x & sw_x;
      mask_i <= sw_i;
    end
  end

  p_reset_masks_r1: assert property (@(posedge clk)
    !rst_n |=> mask_x && mask_i);

  p_x_sw_no_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr && !take && !rti_restore && !mask_x |=> !mask_x);

  p_x_rise_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_x) |-> $past(take || rti_restore));

  p_periph_needs_i_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && src_idx > IDX_SWI |-> !mask_i);

  p_xpin_needs_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take && src_idx == IDX_XPIN |-> !mask_x);

  p_swi_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    insn_boundary && req_swi |-> take && src_idx <= IDX_SWI);

  p_por_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_por |-> take && src_idx == IDX_POR);

  p_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take && !insn_boundary |-> src_idx < IDX_XPIN);

  p_entry_sets_i_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> mask_i);

  p_xrel_sets_x_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take && src_idx <= IDX_XPIN |=> mask_x);

  p_other_keeps_x_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take && src_idx > IDX_XPIN |=> mask_x == $past(mask_x));

endmodule

// File: tb/intmask_arb_tb.sv
`timescale 1ns/1ps
module intmask_arb_tb_top;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_por, req_clkmon, req_wdog, req_xpin, req_illop, req_swi;
  logic [N-1:0] req_periph;
  logic insn_boundary, sw_wr, sw_x, sw_i, rti_restore, rti_x, rti_i;
  logic take, mask_x, mask_i;
  logic [3:0] src_idx;
  logic [15:0] vec_addr;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intmask_arb dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    {req_por, req_clkmon, req_wdog, req_xpin, req_illop, req_swi} = '0;
    req_periph = '0; insn_boundary = 0;
    {sw_wr, sw_x, sw_i, rti_restore, rti_x, rti_i} = '0;
  endtask

  task automatic sw_set(input logic x, input logic i);
    @(negedge clk); idle(); sw_wr = 1; sw_x = x; sw_i = i;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    chk("R1 mask_x", mask_x, 1); chk("R1 mask_i", mask_i, 1);
    chk("R12 idle take", take, 0); chk("R12 idle idx", src_idx, 0); chk("R12 idle vec", vec_addr, 0);
  endtask

  task automatic t_masked();
    @(negedge clk); idle(); insn_boundary = 1; req_periph[2] = 1; req_xpin = 1;
    #0.5 chk("R5 both masked", take, 0);
    req_swi = 1;
    #0.5 chk("R6 swi take", take, 1); chk("R6 swi idx", src_idx, 5); chk("R11 swi vec", vec_addr, 16'hFFF6);
    @(negedge clk); idle();
    chk("R10 swi keeps x", mask_x, 1); chk("R10 swi i", mask_i, 1);
  endtask

  task automatic t_sw_write();
    sw_set(0, 0); chk("R2 clear x", mask_x, 0); chk("R2 clear i", mask_i, 0);
    sw_set(1, 1); chk("R2 x not set", mask_x, 0); chk("R2 set i", mask_i, 1);
    sw_set(1, 0); chk("R2 x still 0", mask_x, 0); chk("R2 i 0", mask_i, 0);
  endtask

  task automatic t_priority();
    @(negedge clk); idle(); insn_boundary = 1;
    {req_por, req_clkmon, req_wdog, req_xpin, req_illop, req_swi} = '1; req_periph = 8'b1010_0100;
    #0.1 chk("R7 por", src_idx, 0); chk("R11 por vec", vec_addr, 16'hFFFE);
    req_por = 0;    #0.1 chk("R7 clkmon", src_idx, 1); chk("R11 clkmon vec", vec_addr, 16'hFFFC);
    req_clkmon = 0; #0.1 chk("R7 wdog", src_idx, 2); chk("R11 wdog vec", vec_addr, 16'hFFFA);
    req_wdog = 0;   #0.1 chk("R7 xpin", src_idx, 3); chk("R11 xpin vec", vec_addr, 16'hFFF4);
    req_xpin = 0;   #0.1 chk("R7 illop", src_idx, 4); chk("R11 illop vec", vec_addr, 16'hFFF8);
    req_illop = 0;  #0.1 chk("R7 swi", src_idx, 5);
    req_swi = 0;    #0.1 chk("R8 periph2", src_idx, 8); chk("R8 periph2 vec", vec_addr, 16'hFFEE);
    req_periph = '1; #0.1 chk("R8 periph0", src_idx, 6); chk("R8 periph0 vec", vec_addr, 16'hFFF2);
    req_periph = 8'h80; #0.1 chk("R8 periph7", src_idx, 13); chk("R8 periph7 vec", vec_addr, 16'hFFE4);
    idle(); #0.1 chk("R12 idx back to 0", src_idx, 0);
  endtask

  task automatic t_boundary();
    @(negedge clk); idle(); req_illop = 1; req_periph = 8'h01;
    #0.3 chk("R9 no boundary", take, 0);
    req_wdog = 1;
    #0.3 chk("R9 reset anytime", take, 1); chk("R9 wdog idx", src_idx, 2);
    idle();
    #0.3 chk("R5 xpin ignores I", 32'(mask_i), 0);
  endtask

  task automatic t_entry();
    @(negedge clk); idle(); insn_boundary = 1; req_periph[0] = 1;
    #0.5 chk("R5 periph taken", take, 1);
    @(negedge clk); idle();
    chk("R10 periph sets i", mask_i, 1); chk("R10 periph keeps x", mask_x, 0);
    @(negedge clk); idle(); insn_boundary = 1; req_xpin = 1;
    #0.5 chk("R5 xpin with I set", take, 1); chk("R5 xpin idx", src_idx, 3);
    @(negedge clk); idle();
    chk("R10 xpin sets x", mask_x, 1); chk("R10 xpin sets i", mask_i, 1);
  endtask

  task automatic t_rti();
    @(negedge clk); idle(); rti_restore = 1; rti_x = 0; rti_i = 0;
    @(negedge clk); idle();
    chk("R3 restore x0", mask_x, 0); chk("R3 restore i0", mask_i, 0);
    @(negedge clk); idle(); rti_restore = 1; rti_x = 1; rti_i = 0;
    @(negedge clk); idle();
    chk("R3 restore sets x", mask_x, 1); chk("R3 restore i", mask_i, 0);
  endtask

  task automatic t_precedence();
    @(negedge clk); idle(); rti_restore = 1; rti_x = 0; rti_i = 1; sw_wr = 1; sw_x = 0; sw_i = 0;
    @(negedge clk); idle();
    chk("R4 restore over sw i", mask_i, 1); chk("R4 restore over sw x", mask_x, 0);
    sw_set(0, 0);
    @(negedge clk); idle(); insn_boundary = 1; req_periph[5] = 1; rti_restore = 1; rti_x = 1; rti_i = 0;
    @(negedge clk); idle();
    chk("R4 take over restore i", mask_i, 1); chk("R4 take over restore x", mask_x, 0);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #0.5 t_reset();
    t_masked();
    t_sw_write();
    t_priority();
    t_boundary();
    t_entry();
    t_rti();
    t_precedence();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule